// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the processor's system control registers and serves one request per clock. A request names a register index and says whether it reads or writes. It also carries 64-bit write data, the requester's privilege level and whether the core is in 64-bit mode. Each request is screened before it takes effect. The screen covers privilege, register existence, operating mode, reserved bits and illegal flag combinations.

A request that fails any rule raises a one-cycle general-protection strobe instead of acting. The strobe always stands for an error code of zero, and no register changes. A legal read returns its value one cycle later. A legal write lands at the clock edge.

The block drives a few control flags straight to the rest of the core. These are protection enable, paging enable, supervisor write protect, the paging table base and the task priority threshold.

Top module: `ctl_reg_bank`

## Requirements
- R1: Any request whose privilege level is not 0 faults, whether it reads or writes.
- R2: Only indices 0, 2, 3, 4 and 8 exist. Index 1 and every other index fault on both read and write.
- R3: Index 8 (task priority) exists only in 64-bit mode and faults in any other mode. It stores 4 bits [3:0]. A write with any of bits 63:4 set faults.
- R4: In 64-bit mode, a write to index 0 or 4 with any nonzero bit in 63:32 faults. In 32-bit mode, bits 63:32 of all write data are ignored and taken as zero. Index 4 stores bits 31:0.
- R5: A write to index 0 with bit 31 (paging enable) set and bit 0 (protection enable) clear faults.
- R6: Index 0 stores bits 31:0, and its bit 4 always reads as 1 whatever was written.
- R7: Index 2 (fault address) stores every written bit with no address-width check.
- R8: A 64-bit-mode write to index 3 (table base) with any of bits 51:40 set faults. Index 3 keeps bits 63:52, 39:12, 4 and 3, and all other bits read as zero.
- R9: A legal read raises rsp_valid one cycle later, with the value on rsp_rdata. In 32-bit mode the value is the low 32 bits, zero-extended. Otherwise rsp_valid is low and rsp_rdata is zero.
- R10: A faulting request raises gp_fault for exactly one cycle, the cycle after the request. It never coincides with rsp_valid and changes no register.
- R11: After each edge, prot_en, paging_en and wr_protect follow index 0 bits 0, 31 and 16. table_base follows index 3 bits 63:12, and task_prio follows index 8.
- R12: After reset, index 0 holds 0x10 and all other registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Register index |
| req_wdata | input | 64 | Write data |
| req_cpl | input | 2 | Privilege level of the requester |
| req_long | input | 1 | 1 = 64-bit mode, 0 = any 32-bit mode |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| gp_fault | output | 1 | General-protection strobe, error code zero |
| prot_en | output | 1 | Protection enable flag |
| paging_en | output | 1 | Paging enable flag |
| wr_protect | output | 1 | Supervisor write-protect flag |
| table_base | output | 52 | Paging table base, address bits 63:12 |
| task_prio | output | 4 | Task priority threshold |

## Verification
The block has a fixed layout with no tuning parameters, so the bench builds it exactly as it ships. Because the index is only 4 bits wide, random choice reaches all sixteen codes, including the undefined ones. Mixing random privilege levels and mode bits with data that is partly scrubbed of reserved bits produces both legal and illegal writes in volume. Directed cases pin down the paging-without-protection write, the upper-half write that is allowed in 32-bit mode, and the priority register outside 64-bit mode.

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_idx,
  input  logic [63:0] req_wdata,
  input  logic [1:0]  req_cpl,
  input  logic        req_long,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        gp_fault,
  output logic        prot_en,
  output logic        paging_en,
  output logic        wr_protect,
  output logic [51:0] table_base,
  output logic [3:0]  task_prio
);
  localparam logic [63:0] TBL_KEEP  = 64'hFFF0_00FF_FFFF_F018;
  localparam logic [31:0] SYS_FIXED = 32'h0000_0010;

  logic [31:0] sys_q, ext_q;
  logic [63:0] fa_q, tbl_q;
  logic [3:0]  prio_q;

  logic [63:0] wd;
  assign wd = req_long ? req_wdata : {32'h0, req_wdata[31:0]};

  logic sel_sys, sel_fa, sel_tbl, sel_ext, sel_prio;
  assign sel_sys  = (req_idx == 4'd0);
  assign sel_fa   = (req_idx == 4'd2);
  assign sel_tbl  = (req_idx == 4'd3);
  assign sel_ext  = (req_idx == 4'd4);
  assign sel_prio = (req_idx == 4'd8);

  logic exists, bad_data, fault_now, do_wr, do_rd;
  assign exists = sel_sys | sel_fa | sel_tbl | sel_ext | (sel_prio & req_long);
  assign bad_data = req_write & (
      ((sel_sys | sel_ext) & (|wd[63:32])) |
      (sel_sys & wd[31] & ~wd[0]) |
      (sel_tbl & (|wd[51:40])) |
      (sel_prio & (|wd[63:4])));
  assign fault_now = req_valid & ((req_cpl != 2'd0) | ~exists | bad_data);
  assign do_wr = req_valid & req_write & ~fault_now;
  assign do_rd = req_valid & ~req_write & ~fault_now;

  logic [63:0] rd_raw, rd_val;
  always_comb begin
    rd_raw = '0;
    unique case (1'b1)
      sel_sys:  rd_raw = {32'h0, sys_q};
      sel_fa:   rd_raw = fa_q;
      sel_tbl:  rd_raw = tbl_q;
      sel_ext:  rd_raw = {32'h0, ext_q};
      sel_prio: rd_raw = {60'h0, prio_q};
      default:  rd_raw = '0;
    endcase
  end
  assign rd_val = req_long ? rd_raw : {32'h0, rd_raw[31:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= SYS_FIXED;
      ext_q  <= '0;
      fa_q   <= '0;
      tbl_q  <= '0;
      prio_q <= '0;
    end else if (do_wr) begin
      if (sel_sys)  sys_q  <= wd[31:0] | SYS_FIXED;
      if (sel_ext)  ext_q  <= wd[31:0];
      if (sel_fa)   fa_q   <= wd;
      if (sel_tbl)  tbl_q  <= wd & TBL_KEEP;
      if (sel_prio) prio_q <= wd[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      gp_fault  <= 1'b0;
    end else begin
      rsp_valid <= do_rd;
      rsp_rdata <= do_rd ? rd_val : '0;
      gp_fault  <= fault_now;
    end
  end

  assign prot_en    = sys_q[0];
  assign paging_en  = sys_q[31];
  assign wr_protect = sys_q[16];
  assign table_base = tbl_q[63:12];
  assign task_prio  = prio_q;
endmodule

module ctl_reg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [3:0]  req_idx,
  input logic [1:0]  req_cpl,
  input logic        req_long,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata,
  input logic        gp_fault,
  input logic        prot_en,
  input logic        paging_en,
  input logic        wr_protect,
  input logic [51:0] table_base,
  input logic [3:0]  task_prio
);
  // R1
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_cpl != 2'd0 |=> gp_fault && !rsp_valid);
  // R2
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(req_idx inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd8}) |=> gp_fault);
  // R3
  prio_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_idx == 4'd8 && !req_long |=> gp_fault);
  // R5
  pg_needs_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paging_en |-> prot_en);
  // R6
  fixed_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_idx == 4'd0 && req_cpl == 2'd0 |=> rsp_rdata[4]);
  // R9
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !req_long |=> rsp_rdata[63:32] == 32'h0);
  // R10
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gp_fault && rsp_valid));
  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> $stable({prot_en, paging_en, wr_protect, table_base, task_prio}));
endmodule

bind ctl_reg_bank ctl_reg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_idx(req_idx), .req_cpl(req_cpl), .req_long(req_long),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .gp_fault(gp_fault),
  .prot_en(prot_en), .paging_en(paging_en), .wr_protect(wr_protect),
  .table_base(table_base), .task_prio(task_prio));

// File: tb/ctl_reg_bank_bench.sv
module ctl_reg_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_long = 1'b1;
  logic [3:0] req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0] req_cpl = '0;
  logic rsp_valid, gp_fault, prot_en, paging_en, wr_protect;
  logic [63:0] rsp_rdata;
  logic [51:0] table_base;
  logic [3:0] task_prio;

  always #4 clk = ~clk;

  ctl_reg_bank u_ctl_reg_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .req_cpl(req_cpl), .req_long(req_long),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .gp_fault(gp_fault),
    .prot_en(prot_en), .paging_en(paging_en), .wr_protect(wr_protect),
    .table_base(table_base), .task_prio(task_prio));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_sys = 32'h10, m_ext = '0;
  logic [63:0] m_fa = '0, m_tbl = '0;
  logic [3:0]  m_prio = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string why(input bit w, input logic [3:0] i, input logic [63:0] d,
                                input logic [1:0] cpl, input bit lng);
    if (cpl != 0) return "R1";
    if (!(i inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd8})) return "R2";
    if (i == 8 && !lng) return "R3";
    if (w) begin
      if ((i == 0 || i == 4) && d[63:32] != 0) return "R4";
      if (i == 0 && d[31] && !d[0]) return "R5";
      if (i == 3 && d[51:40] != 0) return "R8";
      if (i == 8 && d[63:4] != 0) return "R3";
    end
    return "";
  endfunction

  function automatic logic [63:0] model_rd(input logic [3:0] i, input bit lng);
    logic [63:0] v;
    case (i)
      4'd0: v = {32'h0, m_sys};
      4'd2: v = m_fa;
      4'd3: v = m_tbl;
      4'd4: v = {32'h0, m_ext};
      default: v = {60'h0, m_prio};
    endcase
    return lng ? v : {32'h0, v[31:0]};
  endfunction

  function automatic string rd_tag(input logic [3:0] i, input bit lng);
    if (!lng) return "R9";
    case (i)
      4'd0: return "R6";
      4'd2: return "R7";
      4'd3: return "R8";
      4'd4: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic op(input bit w, input logic [3:0] i, input logic [63:0] data,
                    input logic [1:0] cpl, input bit lng);
    logic [63:0] d, exp_rd;
    string r;
    bit f;
    req_valid = 1'b1; req_write = w; req_idx = i; req_wdata = data;
    req_cpl = cpl; req_long = lng;
    d = lng ? data : {32'h0, data[31:0]};
    r = why(w, i, d, cpl, lng);
    f = (r != "");
    exp_rd = (!f && !w) ? model_rd(i, lng) : 64'h0;
    if (!f && w) begin
      case (i)
        4'd0: m_sys = d[31:0] | 32'h10;
        4'd2: m_fa = d;
        4'd3: m_tbl = d & 64'hFFF0_00FF_FFFF_F018;
        4'd4: m_ext = d[31:0];
        default: m_prio = d[3:0];
      endcase
    end
    @(negedge clk);
    chk(gp_fault == f, f ? r : "R10", "gp_fault", {63'h0, gp_fault}, {63'h0, f});
    chk(rsp_valid == (!f && !w), "R9", "rsp_valid", {63'h0, rsp_valid}, {63'h0, !f && !w});
    chk(rsp_rdata == exp_rd, (!f && !w) ? rd_tag(i, lng) : "R9", "rsp_rdata", rsp_rdata, exp_rd);
    chk({prot_en, paging_en, wr_protect} == {m_sys[0], m_sys[31], m_sys[16]},
        f ? "R10" : "R11", "flags", {61'h0, prot_en, paging_en, wr_protect},
        {61'h0, m_sys[0], m_sys[31], m_sys[16]});
    chk(table_base == m_tbl[63:12] && task_prio == m_prio, f ? "R10" : "R11", "base/prio",
        {table_base, task_prio, 8'h0}, {m_tbl[63:12], m_prio, 8'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!rsp_valid && !gp_fault && !prot_en && !paging_en && !wr_protect &&
        table_base == 0 && task_prio == 0, "R12", "reset outputs",
        {57'h0, rsp_valid, gp_fault, prot_en, paging_en, wr_protect, |table_base, |task_prio}, 64'h0);
    op(0, 4'd0, '0, 2'd0, 1);                       // R12 and R6: 0x10
    op(0, 4'd3, '0, 2'd0, 1);                       // R12
    op(1, 4'd0, 64'h8000_0000, 2'd0, 1);            // R5
    op(1, 4'd0, 64'h8001_0001, 2'd0, 1);            // R11
    op(0, 4'd0, '0, 2'd0, 1);                       // R6
    op(1, 4'd4, 64'h1_0000_0000, 2'd0, 1);          // R4 fault
    op(1, 4'd4, 64'hFFFF_FFFF_1234_5678, 2'd0, 0);  // R4 ignored upper
    op(0, 4'd4, '0, 2'd0, 1);
    op(0, 4'd1, '0, 2'd0, 1);                       // R2
    op(1, 4'd8, 64'h5, 2'd0, 0);                    // R3
    op(1, 4'd8, 64'h15, 2'd0, 1);                   // R3
    op(1, 4'd8, 64'h9, 2'd0, 1);
    op(0, 4'd8, '0, 2'd3, 1);                       // R1
    op(1, 4'd3, 64'h0000_0100_0000_0000, 2'd0, 1);  // R8
    op(1, 4'd3, 64'hFFF0_00FF_FFFF_FFFF, 2'd0, 1);  // R8 mask
    op(0, 4'd3, '0, 2'd0, 1);
    op(1, 4'd2, 64'hDEAD_BEEF_CAFE_F00D, 2'd0, 1);  // R7
    op(0, 4'd2, '0, 2'd0, 0);                       // R9
    op(0, 4'd2, '0, 2'd0, 1);
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] i;
      logic [63:0] d;
      logic [1:0] c;
      bit lng;
      c = ($urandom % 8 == 0) ? 2'($urandom) : 2'd0;
      if ($urandom % 6 == 0) i = 4'($urandom);
      else case ($urandom % 5)
        0: i = 4'd0; 1: i = 4'd2; 2: i = 4'd3; 3: i = 4'd4; default: i = 4'd8;
      endcase
      lng = ($urandom % 4 != 0);
      d = {$urandom, $urandom};
      if ($urandom % 3 != 0) begin
        if (i == 0 || i == 4) d[63:32] = '0;
        if (i == 3) d[51:40] = '0;
        if (i == 8) d[63:4] = '0;
        if (i == 0 && $urandom % 2 == 0) d[0] = 1'b1;
      end
      op($urandom % 2 == 0, i, d, c, lng);
    end
    req_valid = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule